// File: doc/BRIEF.md
# Paired-Page Address Translation Buffer

This block translates virtual addresses into 36-bit physical addresses through a small, fully associative table of mappings. Every slot covers two neighbouring virtual pages. The two pages share one tag and one address-space identifier, and each page has its own physical frame and its own valid bit. Each slot also has its own page size, which can be any power-of-four multiple of 4 KB from 4 KB up to 16 MB. A lookup compares the incoming address and identifier against every slot in the same cycle. One cycle later it reports one of three outcomes: a translated address, a miss, or a match on a page that is not valid. External control logic uses the miss and invalid indications to trap and refill the table in software.

The table is filled through a write port. The port either targets an explicit slot or, in random mode, the slot named by a free-running down-counter. The counter lowest value is a wired floor, so slots below the floor are never chosen for random replacement. The current counter value is visible on an output so the refill handler knows which slot a random write will replace. When two or more slots claim the same address, the lowest-numbered slot wins and a multiple-match flag is raised.

Top module: `tlb_pair_xlate`

## Requirements
- R1: The table holds NUM_ENT (default 48) slots, all searched in the same lookup. A slot matches only if its ASID equals `lk_asid` and its tag equals the lookup address on every bit above the page-pair boundary of the slot's page size. A slot that has not been written since reset never matches.
- R2: The size code `wr_size` c in 0..6 sets a page of 4 KB·4^c, which gives 12+2c offset bits. The pair then spans 13+2c address bits, so tag bits below that position are ignored. `wr_vpn2` carries virtual address bits 39:13.
- R3: Virtual address bit 12+2c selects the frame: 0 selects the even frame (`wr_pfn_even`) and 1 selects the odd frame (`wr_pfn_odd`). The frame number holds physical address bits 35:12. On a hit, `rsp_pa` takes the frame bits above the page offset and takes the low 12+2c bits from the virtual address.
- R4: When no slot matches, the response has `rsp_miss`=1, `rsp_hit`=0, `rsp_invalid`=0, `rsp_pa`=0 and `rsp_idx`=0.
- R5: When the chosen slot matches but the selected page's valid bit is 0, the response has `rsp_invalid`=1, `rsp_hit`=0, `rsp_miss`=0 and `rsp_pa`=0. `rsp_idx` still names the slot.
- R6: When several slots match, the lowest-numbered one gives the result and `rsp_idx`, and `rsp_multi`=1. With exactly one match, `rsp_multi`=0.
- R7: `rnd_idx` is NUM_ENT-1 after reset and decreases by one on every clock. From WIRED_FLOOR (default 0) it wraps back to NUM_ENT-1.
- R8: A write with `wr_rand`=1 stores into slot `rnd_idx` as seen at that clock edge, and `wr_idx` is ignored. A write with `wr_rand`=0 stores into slot `wr_idx`. If `wr_idx` ≥ NUM_ENT, the write is dropped.
- R9: A lookup sampled on one clock edge drives `rsp_valid`=1 and its result right after that edge. A write is seen by lookups sampled on later edges, not by a lookup sampled on the same edge.
- R10: Synchronous reset empties every slot and clears all response outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_req | input | 1 | Lookup request |
| lk_va | input | 40 | Virtual address to translate |
| lk_asid | input | 8 | Current address-space identifier |
| wr_en | input | 1 | Write a slot this cycle |
| wr_rand | input | 1 | 1: target slot from counter, 0: from `wr_idx` |
| wr_idx | input | 6 | Explicit target slot |
| wr_size | input | 3 | Page-size code, 0 (4 KB) to 6 (16 MB) |
| wr_vpn2 | input | 27 | Page-pair tag, virtual address bits 39:13 |
| wr_asid | input | 8 | Identifier stored with the slot |
| wr_pfn_even | input | 24 | Even-page frame, physical address bits 35:12 |
| wr_v_even | input | 1 | Even-page valid |
| wr_pfn_odd | input | 24 | Odd-page frame, physical address bits 35:12 |
| wr_v_odd | input | 1 | Odd-page valid |
| rnd_idx | output | 6 | Slot a random write would use now |
| rsp_valid | output | 1 | Lookup result present |
| rsp_hit | output | 1 | Translation found with valid page |
| rsp_miss | output | 1 | No slot matched |
| rsp_invalid | output | 1 | Slot matched, selected page not valid |
| rsp_multi | output | 1 | More than one slot matched |
| rsp_idx | output | 6 | Slot that produced the result |
| rsp_pa | output | 36 | Translated physical address |

## Verification
The search is tried against three slots of different sizes (4 KB, 64 KB and 16 MB). For each size there are addresses on both the even and the odd half, an address just past the pair, a wrong identifier, and different upper address bits. These cases separate errors in the masking of the tag, in the choice of frame, and in the splicing of the offset. A page with its valid bit clear shows that an invalid match is reported apart from a miss. Two overlapping slots of different sizes check that the lowest slot wins and that the multiple-match flag is raised. Writes at an out-of-range slot, a write and lookup on the same edge, a random write, and a long run of counter samples across the wrap show the visibility rule and the replacement rule.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    localparam int VA_W     = 40;
    localparam int PA_W     = 36;
    localparam int ASID_W   = 8;
    localparam int MIN_OFF  = 12;
    localparam int SIZE_W   = 3;
    localparam int MAX_CODE = 6;
    localparam int VPN2_W   = VA_W - MIN_OFF - 1;
    localparam int PFN_W    = PA_W - MIN_OFF;

    typedef struct packed {
        logic              used;
        logic [SIZE_W-1:0] size;
        logic [VPN2_W-1:0] vpn2;
        logic [ASID_W-1:0] asid;
        logic [PFN_W-1:0]  pfn_e;
        logic              v_e;
        logic [PFN_W-1:0]  pfn_o;
        logic              v_o;
    } tlb_entry_t;

    // Number of in-page offset bits for a size code; codes above the
    // largest size behave as the largest size.
    function automatic int page_shift(logic [SIZE_W-1:0] code);
        int c;
        c = int'(code);
        if (c > MAX_CODE) c = MAX_CODE;
        return MIN_OFF + 2 * c;
    endfunction

    // Tag bits that take part in the comparison for a size code.
    function automatic logic [VPN2_W-1:0] tag_care(logic [SIZE_W-1:0] code);
        return {VPN2_W{1'b1}} << (page_shift(code) - MIN_OFF);
    endfunction

    // Physical-address bits that come from the virtual offset.
    function automatic logic [PA_W-1:0] offset_mask(logic [SIZE_W-1:0] code);
        return ~({PA_W{1'b1}} << page_shift(code));
    endfunction

endpackage

// File: rtl/tlb_slot_cmp.sv
module tlb_slot_cmp
    import tlb_pkg::*;
(
    input  logic              used,
    input  logic [SIZE_W-1:0] size,
    input  logic [VPN2_W-1:0] vpn2,
    input  logic [ASID_W-1:0] asid,
    input  logic [VA_W-1:0]   va,
    input  logic [ASID_W-1:0] cur_asid,
    output logic              match,
    output logic              odd
);
    logic [VPN2_W-1:0] diff;

    always_comb begin
        diff  = (vpn2 ^ va[VA_W-1:MIN_OFF+1]) & tag_care(size);
        match = used && (asid == cur_asid) && (diff == '0);
        odd   = va[page_shift(size)];
    end
endmodule

// File: rtl/tlb_first_hit.sv
module tlb_first_hit #(
    parameter int NUM_ENT = 48,
    localparam int IDX_W  = $clog2(NUM_ENT)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_ENT-1:0]  match,
    output logic                found,
    output logic [IDX_W-1:0]    idx,
    output logic                multi
);
    always_comb begin
        found = 1'b0;
        multi = 1'b0;
        idx   = '0;
        for (int i = NUM_ENT - 1; i >= 0; i--) begin
            if (match[i]) begin
                if (found) multi = 1'b1;
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end

    // R6: the chosen slot is a matching one and no lower slot matches
    assert_lowest_pick_R6: assert property (@(posedge clk) disable iff (rst)
        found |-> (match[idx] && ((match & ((NUM_ENT'(1) << idx) - NUM_ENT'(1))) == '0)));

    // R6: the multiple-match flag agrees with the count of matches
    assert_multi_count_R6: assert property (@(posedge clk) disable iff (rst)
        multi == ($countones(match) > 1));
endmodule

// File: rtl/tlb_rand_ctr.sv
module tlb_rand_ctr #(
    parameter int NUM_ENT     = 48,
    parameter int WIRED_FLOOR = 0,
    localparam int IDX_W      = $clog2(NUM_ENT)
) (
    input  logic             clk,
    input  logic             rst,
    output logic [IDX_W-1:0] rnd
);
    localparam logic [IDX_W-1:0] TOP = IDX_W'(NUM_ENT - 1);
    localparam logic [IDX_W-1:0] BOT = IDX_W'(WIRED_FLOOR);

    always_ff @(posedge clk) begin
        if (rst)             rnd <= TOP;
        else if (rnd == BOT) rnd <= TOP;
        else                 rnd <= rnd - 1'b1;
    end

    // R7: the counter never leaves the table
    assert_rnd_range_R7: assert property (@(posedge clk) disable iff (rst)
        !(rnd > TOP));

    // R7: one step down per clock, wrapping at the floor
    assert_rnd_step_R7: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (($past(rnd) == BOT) ? (rnd == TOP) : (rnd == $past(rnd) - 1'b1)));
endmodule

// File: rtl/tlb_pair_xlate.sv
module tlb_pair_xlate
    import tlb_pkg::*;
#(
    parameter int NUM_ENT     = 48,
    parameter int WIRED_FLOOR = 0,
    localparam int IDX_W      = $clog2(NUM_ENT)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lk_req,
    input  logic [VA_W-1:0]   lk_va,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic              wr_en,
    input  logic              wr_rand,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [SIZE_W-1:0] wr_size,
    input  logic [VPN2_W-1:0] wr_vpn2,
    input  logic [ASID_W-1:0] wr_asid,
    input  logic [PFN_W-1:0]  wr_pfn_even,
    input  logic              wr_v_even,
    input  logic [PFN_W-1:0]  wr_pfn_odd,
    input  logic              wr_v_odd,
    output logic [IDX_W-1:0]  rnd_idx,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_miss,
    output logic              rsp_invalid,
    output logic              rsp_multi,
    output logic [IDX_W-1:0]  rsp_idx,
    output logic [PA_W-1:0]   rsp_pa
);
    localparam logic [IDX_W:0] ENT_LIMIT = (IDX_W + 1)'(NUM_ENT);

    tlb_entry_t        ent_q [NUM_ENT];
    tlb_entry_t        new_ent;
    logic [IDX_W-1:0]  wr_tgt;
    logic              wr_ok;

    logic [NUM_ENT-1:0] match_vec;
    logic [NUM_ENT-1:0] odd_vec;
    logic               found;
    logic               multi;
    logic [IDX_W-1:0]   sel_idx;
    tlb_entry_t         sel_ent;
    logic               sel_odd;
    logic               sel_v;
    logic [PFN_W-1:0]   sel_pfn;
    logic [PA_W-1:0]    sel_mask;
    logic [PA_W-1:0]    xl_pa;

    // Replacement counter
    tlb_rand_ctr #(.NUM_ENT(NUM_ENT), .WIRED_FLOOR(WIRED_FLOOR)) u_rand (
        .clk (clk),
        .rst (rst),
        .rnd (rnd_idx)
    );

    // Write path
    always_comb begin
        new_ent.used  = 1'b1;
        new_ent.size  = wr_size;
        new_ent.vpn2  = wr_vpn2;
        new_ent.asid  = wr_asid;
        new_ent.pfn_e = wr_pfn_even;
        new_ent.v_e   = wr_v_even;
        new_ent.pfn_o = wr_pfn_odd;
        new_ent.v_o   = wr_v_odd;
        wr_tgt        = wr_rand ? rnd_idx : wr_idx;
        wr_ok         = wr_en && ({1'b0, wr_tgt} < ENT_LIMIT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_ENT; i++) ent_q[i] <= '0;
        end else if (wr_ok) begin
            ent_q[wr_tgt] <= new_ent;
        end
    end

    // Parallel compare, one comparator per slot
    for (genvar g = 0; g < NUM_ENT; g++) begin : g_slot
        tlb_slot_cmp u_cmp (
            .used     (ent_q[g].used),
            .size     (ent_q[g].size),
            .vpn2     (ent_q[g].vpn2),
            .asid     (ent_q[g].asid),
            .va       (lk_va),
            .cur_asid (lk_asid),
            .match    (match_vec[g]),
            .odd      (odd_vec[g])
        );
    end

    tlb_first_hit #(.NUM_ENT(NUM_ENT)) u_pick (
        .clk   (clk),
        .rst   (rst),
        .match (match_vec),
        .found (found),
        .idx   (sel_idx),
        .multi (multi)
    );

    // Frame selection and address splice
    always_comb begin
        sel_ent  = ent_q[sel_idx];
        sel_odd  = odd_vec[sel_idx];
        sel_pfn  = sel_odd ? sel_ent.pfn_o : sel_ent.pfn_e;
        sel_v    = sel_odd ? sel_ent.v_o   : sel_ent.v_e;
        sel_mask = offset_mask(sel_ent.size);
        xl_pa    = ({sel_pfn, {MIN_OFF{1'b0}}} & ~sel_mask) | (lk_va[PA_W-1:0] & sel_mask);
    end

    // Registered response
    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid   <= 1'b0;
            rsp_hit     <= 1'b0;
            rsp_miss    <= 1'b0;
            rsp_invalid <= 1'b0;
            rsp_multi   <= 1'b0;
            rsp_idx     <= '0;
            rsp_pa      <= '0;
        end else begin
            rsp_valid   <= lk_req;
            rsp_hit     <= lk_req && found && sel_v;
            rsp_miss    <= lk_req && !found;
            rsp_invalid <= lk_req && found && !sel_v;
            rsp_multi   <= lk_req && multi;
            rsp_idx     <= (lk_req && found) ? sel_idx : '0;
            rsp_pa      <= (lk_req && found && sel_v) ? xl_pa : '0;
        end
    end

    // R4 R5: exactly one outcome per response
    assert_one_outcome_R4: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> ($countones({rsp_hit, rsp_miss, rsp_invalid}) == 1));

    // R9: a response follows a request by one cycle
    assert_resp_latency_R9: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(lk_req));

    // R3: the low 4 KB offset always passes straight through on a hit
    assert_offset_pass_R3: assert property (@(posedge clk) disable iff (rst)
        rsp_hit |-> (rsp_pa[MIN_OFF-1:0] == $past(lk_va[MIN_OFF-1:0])));

    // R6: a multiple match is never reported as a miss
    assert_multi_not_miss_R6: assert property (@(posedge clk) disable iff (rst)
        rsp_multi |-> !rsp_miss);
endmodule

// File: tb/tb_tlb_pair_xlate.sv
module tb_tlb_pair_xlate;
    localparam int CLK_PERIOD = 10;
    localparam int NUM_ENT    = 48;
    localparam int FLOOR      = 0;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lk_req = 1'b0;
    logic [39:0] lk_va = '0;
    logic [7:0]  lk_asid = '0;
    logic        wr_en = 1'b0;
    logic        wr_rand = 1'b0;
    logic [5:0]  wr_idx = '0;
    logic [2:0]  wr_size = '0;
    logic [26:0] wr_vpn2 = '0;
    logic [7:0]  wr_asid = '0;
    logic [23:0] wr_pfn_even = '0;
    logic        wr_v_even = 1'b0;
    logic [23:0] wr_pfn_odd = '0;
    logic        wr_v_odd = 1'b0;
    logic [5:0]  rnd_idx;
    logic        rsp_valid, rsp_hit, rsp_miss, rsp_invalid, rsp_multi;
    logic [5:0]  rsp_idx;
    logic [35:0] rsp_pa;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    tlb_pair_xlate #(.NUM_ENT(NUM_ENT), .WIRED_FLOOR(FLOOR)) dut (
        .clk(clk), .rst(rst), .lk_req(lk_req), .lk_va(lk_va), .lk_asid(lk_asid),
        .wr_en(wr_en), .wr_rand(wr_rand), .wr_idx(wr_idx), .wr_size(wr_size),
        .wr_vpn2(wr_vpn2), .wr_asid(wr_asid), .wr_pfn_even(wr_pfn_even),
        .wr_v_even(wr_v_even), .wr_pfn_odd(wr_pfn_odd), .wr_v_odd(wr_v_odd),
        .rnd_idx(rnd_idx), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_miss(rsp_miss), .rsp_invalid(rsp_invalid), .rsp_multi(rsp_multi),
        .rsp_idx(rsp_idx), .rsp_pa(rsp_pa)
    );

    typedef struct packed {
        logic [39:0] va;
        logic [7:0]  asid;
        logic [2:0]  hmi;   // {hit, miss, invalid}
        logic [35:0] pa;
        logic [5:0]  idx;
    } vec_t;

    // Slots 0 (4 KB), 5 (64 KB), 10 (16 MB) loaded before the walk
    localparam int NVEC = 12;
    localparam vec_t VECS [NVEC] = '{
        '{40'h00_1234_4ABC, 8'h11, 3'b100, 36'h0_000A_BABC, 6'd0},   // R3 even 4K
        '{40'h00_1234_5ABC, 8'h11, 3'b100, 36'h0_000C_DABC, 6'd0},   // R3 odd 4K
        '{40'h00_1234_4ABC, 8'h22, 3'b010, 36'h0,           6'd0},   // R1 asid
        '{40'h00_1234_6000, 8'h11, 3'b010, 36'h0,           6'd0},   // R2 next pair
        '{40'h00_4000_1234, 8'h22, 3'b100, 36'h0_8000_1234, 6'd5},   // R2 64K
        '{40'h00_4001_0010, 8'h22, 3'b001, 36'h0,           6'd5},   // R5 invalid odd
        '{40'h00_4000_FFFF, 8'h22, 3'b100, 36'h0_8000_FFFF, 6'd5},   // R3 top of page
        '{40'h00_4002_0000, 8'h22, 3'b010, 36'h0,           6'd0},   // R2 past pair
        '{40'h00_0A12_3456, 8'h33, 3'b100, 36'hF_0012_3456, 6'd10},  // R2 16M even
        '{40'h00_0BFF_FFFF, 8'h33, 3'b100, 36'h0_01FF_FFFF, 6'd10},  // R3 16M odd
        '{40'hFF_0A12_3456, 8'h33, 3'b010, 36'h0,           6'd0},   // R1 upper bits
        '{40'h00_7000_0000, 8'h44, 3'b010, 36'h0,           6'd0}    // R8 dropped write
    };

    task automatic check(input bit ok, input string req, input logic [63:0] got,
                         input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
        end
    endtask

    task automatic write_slot(input bit rnd, input logic [5:0] idx, input logic [2:0] sz,
                              input logic [26:0] vpn2, input logic [7:0] asid,
                              input logic [23:0] pe, input bit ve,
                              input logic [23:0] po, input bit vo);
        @(negedge clk);
        wr_en = 1'b1; wr_rand = rnd; wr_idx = idx; wr_size = sz; wr_vpn2 = vpn2;
        wr_asid = asid; wr_pfn_even = pe; wr_v_even = ve; wr_pfn_odd = po; wr_v_odd = vo;
        @(negedge clk);
        wr_en = 1'b0; wr_rand = 1'b0;
    endtask

    task automatic lookup(input logic [39:0] va, input logic [7:0] asid,
                          input logic [2:0] e_hmi, input logic [35:0] e_pa,
                          input logic [5:0] e_idx, input bit e_multi, input string req);
        @(negedge clk);
        lk_req = 1'b1; lk_va = va; lk_asid = asid;
        @(negedge clk);
        lk_req = 1'b0;
        check(rsp_valid == 1'b1, {req, " valid"}, 64'(rsp_valid), 64'd1);
        check({rsp_hit, rsp_miss, rsp_invalid} == e_hmi, {req, " outcome"},
              64'({rsp_hit, rsp_miss, rsp_invalid}), 64'(e_hmi));
        check(rsp_pa == e_pa, {req, " pa"}, 64'(rsp_pa), 64'(e_pa));
        check(rsp_idx == e_idx, {req, " idx"}, 64'(rsp_idx), 64'(e_idx));
        check(rsp_multi == e_multi, {req, " multi"}, 64'(rsp_multi), 64'(e_multi));
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        logic [5:0] r;
        logic [5:0] prev;
        logic [5:0] expn;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R10 reset state
        check(rsp_valid == 1'b0 && rsp_hit == 1'b0 && rsp_pa == '0, "R10 outputs",
              64'({rsp_valid, rsp_hit}), 64'd0);
        check(rnd_idx == 6'(NUM_ENT - 1), "R7 reset value", 64'(rnd_idx), 64'(NUM_ENT - 1));
        lookup(40'h0, 8'h0, 3'b010, 36'h0, 6'd0, 1'b0, "R10 empty table");

        write_slot(1'b0, 6'd0,  3'd0, 27'h0_91A2, 8'h11, 24'h0000AB, 1'b1, 24'h0000CD, 1'b1);
        write_slot(1'b0, 6'd5,  3'd2, 27'h2_0000, 8'h22, 24'h080000, 1'b1, 24'h012340, 1'b0);
        write_slot(1'b0, 6'd10, 3'd6, 27'h0_5000, 8'h33, 24'hF00000, 1'b1, 24'h001000, 1'b1);
        // R8 out-of-range index is dropped (vector 11 looks it up)
        write_slot(1'b0, 6'd50, 3'd0, 27'h3_8000, 8'h44, 24'h000123, 1'b1, 24'h000124, 1'b1);

        for (int i = 0; i < NVEC; i++)
            lookup(VECS[i].va, VECS[i].asid, VECS[i].hmi, VECS[i].pa, VECS[i].idx, 1'b0,
                   $sformatf("R1/R2/R3 vec%0d", i));

        // R9 write and lookup on the same edge: old contents answer
        @(negedge clk);
        wr_en = 1'b1; wr_rand = 1'b0; wr_idx = 6'd30; wr_size = 3'd0; wr_vpn2 = 27'h2_AAAA;
        wr_asid = 8'h55; wr_pfn_even = 24'h000777; wr_v_even = 1'b1;
        wr_pfn_odd = 24'h000778; wr_v_odd = 1'b1;
        lk_req = 1'b1; lk_va = 40'h00_5555_4010; lk_asid = 8'h55;
        @(negedge clk);
        wr_en = 1'b0; lk_req = 1'b0;
        check(rsp_miss == 1'b1, "R9 same-edge miss", 64'(rsp_miss), 64'd1);
        lookup(40'h00_5555_4010, 8'h55, 3'b100, 36'h0_0077_7010, 6'd30, 1'b0, "R9 next lookup");

        // R6 overlapping slots: 64K slot 20 covers slot 0
        write_slot(1'b0, 6'd20, 3'd2, 27'h0_91A0, 8'h11, 24'h000500, 1'b1, 24'h000600, 1'b1);
        lookup(40'h00_1234_4ABC, 8'h11, 3'b100, 36'h0_000A_BABC, 6'd0, 1'b1, "R6 lowest wins");
        lookup(40'h00_1234_8000, 8'h11, 3'b100, 36'h0_0050_8000, 6'd20, 1'b0, "R6 single match");

        // R8 random write ignores wr_idx and uses the counter
        @(negedge clk);
        r = rnd_idx;
        wr_en = 1'b1; wr_rand = 1'b1; wr_idx = (r == 6'd3) ? 6'd4 : 6'd3; wr_size = 3'd0;
        wr_vpn2 = 27'h1_8000; wr_asid = 8'h66; wr_pfn_even = 24'h000999; wr_v_even = 1'b1;
        wr_pfn_odd = 24'h00099A; wr_v_odd = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; wr_rand = 1'b0;
        lookup(40'h00_3000_0123, 8'h66, 3'b100, 36'h0_0099_9123, r, 1'b0, "R8 random target");

        // R7 counter walk across the wrap
        @(negedge clk);
        prev = rnd_idx;
        for (int k = 0; k < 60; k++) begin
            @(negedge clk);
            expn = (prev == 6'(FLOOR)) ? 6'(NUM_ENT - 1) : prev - 6'd1;
            check(rnd_idx == expn, "R7 step", 64'(rnd_idx), 64'(expn));
            prev = rnd_idx;
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule